// File: doc/BRIEF.md
# Leaf Entry Permission Check and Reference/Change Updater

This block takes one 64-bit leaf translation entry together with the details of the access that hit it: the access kind (load, store or fetch), whether the processor is in problem (user) state, whether the check belongs to the process-scoped or the partition-scoped translation stage, a 3-bit permission mask supplied by the access-key logic, and a flag that says the address under translation was itself a guest page-table entry. From these it works out the read/write/execute rights that apply, decides whether the access faults, and builds the fault cause word and a fault class.

When the access is allowed, the block sets the reference bit in the entry, and also the change bit for a store. If that alters the entry, the block issues one 64-bit write request to the entry's address and holds it until memory acknowledges it. For every access other than a store, the block withholds the write right from the permissions it returns. A later store therefore has to come back through the block, and that pass sets the change bit.

Requests are accepted one at a time through a small state machine with four states. ST_IDLE waits with `req_ready` high. ST_CHECK evaluates the captured request and registers the results. ST_WBACK presents the write until `wr_done`. ST_DONE pulses `rsp_valid` for one cycle. The transitions are: IDLE to CHECK on `req_valid`; CHECK to WBACK when the access passes and the entry changed; CHECK to DONE otherwise; WBACK to DONE on `wr_done`; DONE to IDLE always.

Top module: `pte_perm_rc`

## Requirements
- R1: A fetch (access code 2) to an entry whose attribute field, bits [5:4], equals 2'b10 (non-idempotent I/O) faults with class 1 (guarded) and cause bit 28. The permission output is 3'b000, no further check is applied and no write-back is issued.
- R2: In a process-scoped check (`req_part`=0), an entry whose privileged bit (bit 3) is set gives an empty permission set when `req_prob`=1.
- R3: In a process-scoped check in supervisor state (`req_prob`=0) with bit 3 clear, the permission set is the entry's authority bits ANDed with `req_amr`. The authority bits are read = bit 2, write = bit 1 and execute = bit 0. `req_amr` and `rsp_perm` use the same order: [2] read, [1] write, [0] execute.
- R4: In every other case, including every partition-scoped check (`req_part`=1), the permission set is the entry's authority bits alone, and `req_amr` has no effect.
- R5: A load (code 0) needs read, a store (code 1) needs write and a fetch (code 2) needs execute. When the needed right is missing, the result is class 2 (protection) with cause bit 27. Class 0 means no fault, and `rsp_fault` is 1 exactly when the class is non-zero.
- R6: For an access that passes, the updated entry equals the original with the reference bit (bit 8) set. The change bit (bit 7) is also set, but only for a store.
- R7: For any access that is not a store, `rsp_perm[1]` (write) is 0.
- R8: A write-back of the updated entry to `req_addr` happens only when the access passes and the updated entry differs from the original. `wr_valid`, `wr_addr` and `wr_data` hold steady until `wr_done`, and `rsp_valid` follows as a one-cycle pulse.
- R9: On any fault by a store, cause bit 25 is also set. On any fault in a partition-scoped check with `req_pdeaddr`=1, cause bit 21 is also set. With no fault, the cause word is zero.
- R10: After reset, `req_ready` is 1 and `rsp_valid` and `wr_valid` are 0. A request is taken only while `req_ready` is 1, and `req_ready` is low until the response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Block is idle and can take a request |
| req_pte | input | 64 | Leaf entry under check |
| req_addr | input | 64 | Address the entry was read from |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_prob | input | 1 | Problem (user) state |
| req_part | input | 1 | 1 for a partition-scoped check, 0 for process-scoped |
| req_pdeaddr | input | 1 | Translated address was a guest page-table entry |
| req_amr | input | 3 | Access-key permission mask (read, write, execute) |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_perm | output | 3 | Granted rights (read, write, execute) |
| rsp_fault | output | 1 | Access faults |
| rsp_class | output | 2 | Fault class: 0 none, 1 guarded, 2 protection |
| rsp_cause | output | 32 | Fault cause word |
| wr_valid | output | 1 | Entry write-back request |
| wr_addr | output | 64 | Write-back address |
| wr_data | output | 64 | Updated entry |
| wr_done | input | 1 | Write-back acknowledge |

## Verification
The hardest case to reach from the ports is a write-back that memory keeps waiting: the block has to sit in ST_WBACK with its address and data frozen across several cycles. The bench's memory responder is told how many cycles to hold off `wr_done` for each request. A store to a clean entry, stalled for three cycles, drives the block into that state. A second hard case is the masked-permission path, which needs process scope, supervisor state and a clear privileged bit all at the same time. It is reached with a partial mask, so the AND is visible in the output. The same entry is then sent under problem state and under partition scope to show that the mask is ignored there.

// File: rtl/pte_perm_pkg.sv
package pte_perm_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_GUARD = 2'd1,
        CLS_PROT  = 2'd2
    } fclass_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } state_e;

    // cause word bit positions
    localparam int CB_GUARD   = 28;
    localparam int CB_PROT    = 27;
    localparam int CB_STORE   = 25;
    localparam int CB_TBLWALK = 21;

    // attribute encoding for non-idempotent I/O
    localparam logic [1:0] ATT_NIIO = 2'b10;

endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_perm_pkg::*;
(
    input  logic [1:0] att,
    input  logic       priv,
    input  logic [2:0] eaa,
    input  acc_e       acc,
    input  logic       prob,
    input  logic       part,
    input  logic [2:0] amr,
    output logic [2:0] perm,
    output logic       guard,
    output logic       prot
);
    logic [2:0] base;
    logic [2:0] need;

    always_comb begin
        if (!part && priv && prob) begin
            base = 3'b000;
        end else if (!part && !priv && !prob) begin
            base = eaa & amr;
        end else begin
            base = eaa;
        end
    end

    always_comb begin
        unique case (acc)
            ACC_LOAD:  need = 3'b100;
            ACC_STORE: need = 3'b010;
            ACC_FETCH: need = 3'b001;
            default:   need = 3'b000;
        endcase
    end

    assign guard = (acc == ACC_FETCH) && (att == ATT_NIIO);
    assign prot  = !guard && ((need & ~base) != 3'b000);

    always_comb begin
        if (guard) begin
            perm = 3'b000;
        end else if (acc != ACC_STORE) begin
            perm = base & 3'b101;
        end else begin
            perm = base;
        end
    end
endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge #(
    parameter int W       = 64,
    parameter int REF_BIT = 8,
    parameter int CHG_BIT = 7
) (
    input  logic [W-1:0] pte,
    input  logic         is_store,
    output logic [W-1:0] npte,
    output logic         changed
);
    localparam logic [W-1:0] REF_MASK = W'(1) << REF_BIT;
    localparam logic [W-1:0] CHG_MASK = W'(1) << CHG_BIT;

    assign npte    = pte | REF_MASK | (is_store ? CHG_MASK : '0);
    assign changed = (npte != pte);
endmodule

// File: rtl/pte_cause_pack.sv
module pte_cause_pack
    import pte_perm_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          guard,
    input  logic          prot,
    input  logic          is_store,
    input  logic          part,
    input  logic          pdeaddr,
    output logic [CW-1:0] cause
);
    logic fault;
    assign fault = guard || prot;

    always_comb begin
        cause = '0;
        cause[CB_GUARD]   = guard;
        cause[CB_PROT]    = prot;
        cause[CB_STORE]   = fault && is_store;
        cause[CB_TBLWALK] = fault && part && pdeaddr;
    end
endmodule

// File: rtl/pte_perm_rc.sv
module pte_perm_rc
    import pte_perm_pkg::*;
#(
    parameter int W        = 64,
    parameter int AW       = 64,
    parameter int CW       = 32,
    parameter int ATT_LO   = 4,
    parameter int PRIV_BIT = 3,
    parameter int RD_BIT   = 2,
    parameter int WR_BIT   = 1,
    parameter int EX_BIT   = 0,
    parameter int REF_BIT  = 8,
    parameter int CHG_BIT  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [W-1:0]  req_pte,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_acc,
    input  logic          req_prob,
    input  logic          req_part,
    input  logic          req_pdeaddr,
    input  logic [2:0]    req_amr,
    output logic          rsp_valid,
    output logic [2:0]    rsp_perm,
    output logic          rsp_fault,
    output logic [1:0]    rsp_class,
    output logic [CW-1:0] rsp_cause,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    input  logic          wr_done
);
    state_e        state, state_nx;

    logic [W-1:0]  pte_q;
    logic [AW-1:0] addr_q;
    acc_e          acc_q;
    logic          prob_q, part_q, pdea_q;
    logic [2:0]    amr_q;

    logic [2:0]    perm_q;
    logic [CW-1:0] cause_q;
    fclass_e       class_q;
    logic [W-1:0]  npte_q;

    logic [2:0]    perm_c;
    logic          guard_c, prot_c, changed_c;
    logic [W-1:0]  npte_c;
    logic [CW-1:0] cause_c;
    logic          is_store;

    assign is_store = (acc_q == ACC_STORE);

    pte_perm_eval u_eval (
        .att   (pte_q[ATT_LO +: 2]),
        .priv  (pte_q[PRIV_BIT]),
        .eaa   ({pte_q[RD_BIT], pte_q[WR_BIT], pte_q[EX_BIT]}),
        .acc   (acc_q),
        .prob  (prob_q),
        .part  (part_q),
        .amr   (amr_q),
        .perm  (perm_c),
        .guard (guard_c),
        .prot  (prot_c)
    );

    pte_rc_merge #(.W(W), .REF_BIT(REF_BIT), .CHG_BIT(CHG_BIT)) u_rc (
        .pte      (pte_q),
        .is_store (is_store),
        .npte     (npte_c),
        .changed  (changed_c)
    );

    pte_cause_pack #(.CW(CW)) u_cause (
        .guard    (guard_c),
        .prot     (prot_c),
        .is_store (is_store),
        .part     (part_q),
        .pdeaddr  (pdea_q),
        .cause    (cause_c)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (!guard_c && !prot_c && changed_c) ? ST_WBACK : ST_DONE;
            ST_WBACK: if (wr_done) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_q   <= '0;
            addr_q  <= '0;
            acc_q   <= ACC_LOAD;
            prob_q  <= 1'b0;
            part_q  <= 1'b0;
            pdea_q  <= 1'b0;
            amr_q   <= '0;
            perm_q  <= '0;
            cause_q <= '0;
            class_q <= CLS_NONE;
            npte_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    pte_q  <= req_pte;
                    addr_q <= req_addr;
                    acc_q  <= acc_e'(req_acc);
                    prob_q <= req_prob;
                    part_q <= req_part;
                    pdea_q <= req_pdeaddr;
                    amr_q  <= req_amr;
                end
                ST_CHECK: begin
                    perm_q  <= perm_c;
                    cause_q <= cause_c;
                    npte_q  <= npte_c;
                    if (guard_c)     class_q <= CLS_GUARD;
                    else if (prot_c) class_q <= CLS_PROT;
                    else             class_q <= CLS_NONE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        wr_valid  = (state == ST_WBACK);
        rsp_valid = (state == ST_DONE);
        wr_addr   = addr_q;
        wr_data   = npte_q;
        rsp_perm  = perm_q;
        rsp_cause = cause_q;
        rsp_class = class_q;
        rsp_fault = (class_q != CLS_NONE);
    end
endmodule

// File: rtl/pte_perm_rc_chk.sv
module pte_perm_rc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic [2:0]  rsp_perm,
    input logic        rsp_fault,
    input logic [1:0]  rsp_class,
    input logic        wr_valid,
    input logic [63:0] wr_addr,
    input logic [63:0] wr_data,
    input logic        wr_done,
    input logic [1:0]  acc_q
);
    AST_GUARD_NO_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_class == 2'd1 |-> rsp_perm == 3'b000); // R1

    AST_FAULT_MATCHES_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault == (rsp_class != 2'd0)); // R5

    AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_data[8]); // R6

    AST_NONSTORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && acc_q != 2'd1 |-> !rsp_perm[1]); // R7

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_done |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || wr_valid) |-> !req_ready); // R10
endmodule

bind pte_perm_rc pte_perm_rc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_perm  (rsp_perm),
    .rsp_fault (rsp_fault),
    .rsp_class (rsp_class),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_done   (wr_done),
    .acc_q     (acc_q)
);

// File: tb/pte_perm_rc_test.sv
module pte_perm_rc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_pte = '0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_prob = 1'b0;
    logic        req_part = 1'b0;
    logic        req_pdeaddr = 1'b0;
    logic [2:0]  req_amr = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_perm;
    logic        rsp_fault;
    logic [1:0]  rsp_class;
    logic [31:0] rsp_cause;
    logic        wr_valid;
    logic [63:0] wr_addr;
    logic [63:0] wr_data;
    logic        wr_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int stall_req = 0;
    int stall_cnt = 0;
    bit wr_seen = 1'b0;

    typedef struct {
        string       tag;
        logic [2:0]  perm;
        logic [1:0]  cls;
        logic [31:0] cause;
        bit          wr;
        logic [63:0] waddr;
        logic [63:0] wdata;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    pte_perm_rc uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected behaviour from the requirements
    function automatic exp_t model(input string tag, input logic [63:0] pte, input logic [63:0] addr,
                                   input logic [1:0] acc, input bit prob, input bit part,
                                   input bit pdea, input logic [2:0] amr);
        exp_t e;
        logic [2:0] eaa, base, need;
        bit guard, prot, fault;
        logic [63:0] npte;
        eaa   = {pte[2], pte[1], pte[0]};
        guard = (acc == 2'd2) && (pte[5:4] == 2'b10);
        if (!part && pte[3] && prob)        base = 3'b000;
        else if (!part && !pte[3] && !prob) base = eaa & amr;
        else                                base = eaa;
        need  = (acc == 2'd0) ? 3'b100 : (acc == 2'd1) ? 3'b010 : 3'b001;
        prot  = !guard && ((need & ~base) != 0);
        fault = guard || prot;
        e.tag  = tag;
        e.perm = guard ? 3'b000 : ((acc != 2'd1) ? (base & 3'b101) : base);
        e.cls  = guard ? 2'd1 : (prot ? 2'd2 : 2'd0);
        e.cause = '0;
        if (guard) e.cause[28] = 1'b1;
        if (prot)  e.cause[27] = 1'b1;
        if (fault && acc == 2'd1)  e.cause[25] = 1'b1;
        if (fault && part && pdea) e.cause[21] = 1'b1;
        npte = pte | (64'd1 << 8) | ((acc == 2'd1) ? (64'd1 << 7) : 64'd0);
        e.wr    = !fault && (npte != pte);
        e.waddr = addr;
        e.wdata = npte;
        return e;
    endfunction

    task automatic send(input string tag, input logic [63:0] pte, input logic [63:0] addr,
                        input logic [1:0] acc, input bit prob, input bit part,
                        input bit pdea, input logic [2:0] amr, input int stall);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        stall_req   = stall;
        q.push_back(model(tag, pte, addr, acc, prob, part, pdea, amr));
        req_pte     = pte;
        req_addr    = addr;
        req_acc     = acc;
        req_prob    = prob;
        req_part    = part;
        req_pdeaddr = pdea;
        req_amr     = amr;
        req_valid   = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
        req_pte     = '1;
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor and memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (wr_valid && !wr_done) begin
                if (stall_cnt < stall_req) begin
                    stall_cnt++;
                end else begin
                    if (q.size() != 0) begin
                        chk(q[0].wr, {q[0].tag, " R8 unexpected write"}, 64'd1, 64'd0);
                        chk(wr_addr == q[0].waddr, {q[0].tag, " R8 write addr"}, wr_addr, q[0].waddr);
                        chk(wr_data == q[0].wdata, {q[0].tag, " R6 write data"}, wr_data, q[0].wdata);
                    end
                    wr_seen   = 1'b1;
                    wr_done   = 1'b1;
                    stall_cnt = 0;
                end
            end else begin
                wr_done = 1'b0;
            end
            if (rsp_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R10 response with nothing pending", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rsp_perm == e.perm, {e.tag, " perm"}, 64'(rsp_perm), 64'(e.perm));
                    chk(rsp_class == e.cls, {e.tag, " class"}, 64'(rsp_class), 64'(e.cls));
                    chk(rsp_fault == (e.cls != 0), {e.tag, " R5 fault flag"}, 64'(rsp_fault), 64'(e.cls != 0));
                    chk(rsp_cause == e.cause, {e.tag, " cause"}, 64'(rsp_cause), 64'(e.cause));
                    chk(wr_seen == e.wr, {e.tag, " R8 write-back presence"}, 64'(wr_seen), 64'(e.wr));
                end
                wr_seen = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [63:0] HI = 64'hA5C3_0000_1234_0000;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R10 no response after reset", 64'(rsp_valid), 64'd0);
        chk(wr_valid == 1'b0, "R10 no write after reset", 64'(wr_valid), 64'd0);

        // R1 guarded fetch on non-idempotent I/O, partition pde: guard plus table-walk bit
        send("R1 guarded fetch", HI | 64'h127, 64'h1000, 2'd2, 0, 1, 1, 3'b111, 0);
        // R1 tolerant I/O fetch is fine, writes reference bit
        send("R1 tolerant fetch", HI | 64'h37, 64'h1008, 2'd2, 0, 0, 0, 3'b111, 0);
        // R2 privileged page in problem state
        send("R2 priv problem load", HI | 64'h10F, 64'h1010, 2'd0, 1, 0, 0, 3'b111, 0);
        // R3 masked permission, load allowed
        send("R3 masked load", HI | 64'h107, 64'h1018, 2'd0, 0, 0, 0, 3'b100, 0);
        // R3/R5/R9 masked store faults with store bit
        send("R3 R9 masked store", HI | 64'h107, 64'h1020, 2'd1, 0, 0, 0, 3'b100, 0);
        // R4 partition scope ignores mask
        send("R4 partition load", HI | 64'h107, 64'h1028, 2'd0, 0, 1, 0, 3'b000, 0);
        // R4 problem state ignores mask; R6 store sets R and C
        send("R4 R6 problem store", HI | 64'h007, 64'h1030, 2'd1, 1, 0, 0, 3'b000, 0);
        // R8 store with R and C already set: no write
        send("R8 clean store", HI | 64'h187, 64'h1038, 2'd1, 1, 0, 0, 3'b000, 0);
        // R6 R7 load with R clear: write R only, write right removed
        send("R6 R7 load ref", HI | 64'h087, 64'h1040, 2'd0, 1, 0, 0, 3'b000, 0);
        // R9 partition store fault on pde address
        send("R9 partition pde store", HI | 64'h105, 64'h1048, 2'd1, 0, 1, 1, 3'b111, 0);
        // R9 process fault with pde flag: no table-walk bit
        send("R9 process pde store", HI | 64'h105, 64'h1050, 2'd1, 0, 0, 1, 3'b111, 0);
        // R8 stalled write acknowledge
        send("R8 stalled store", HI | 64'h006, 64'h1058, 2'd1, 0, 1, 0, 3'b000, 3);
        // R4 privileged page, supervisor process fetch
        send("R4 priv supervisor fetch", HI | 64'h109, 64'h1060, 2'd2, 0, 0, 0, 3'b000, 0);
        // R4 partition check in problem state ignores privileged bit
        send("R4 partition priv problem", HI | 64'h10C, 64'h1068, 2'd0, 1, 1, 0, 3'b000, 0);
        // R5 fetch without execute right
        send("R5 no exec", HI | 64'h106, 64'h1070, 2'd2, 1, 0, 0, 3'b111, 0);

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready at end", 64'(req_ready), 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule